// File: doc/BRIEF.md
# Video RAM Block Copy Engine

This block moves bytes from anywhere in the 16-bit address space into video RAM. Software first loads two source address bytes and two destination address bytes, then writes a control byte. That write latches both addresses, picks one of two modes and, when the conditions allow, starts the copy. While the engine owns the bus, the processor is held by a stall output. The engine reads one byte and writes it back, which takes two clock cycles per byte.

The engine has two modes. In bulk mode the whole requested length is copied in one go. In blanking mode one 16-byte block is copied each time the video timing enters mode 0 (horizontal blank). After each block the length field counts down, until it wraps and the mode switches itself off. When a batch finishes, the next source and destination addresses are written back into the address registers, so software can read where the copy stopped.

Top module: `vram_block_dma`

## Requirements
- R1: The source address is taken from the two source bytes when the control byte is written, with its low 4 bits forced to zero. The first bus read of a batch uses that address.
- R2: If the aligned source lies in 0x8000–0x9FFF, the control write is rejected. No stall occurs, there is no bus activity, and all registers keep their values.
- R3: The destination is the two destination bytes ANDed with 0x1FF0 and then ORed with 0x8000.
- R4: Control byte bit 7 selects blanking mode and bits [6:0] hold n. In bulk mode the engine copies (n+1)*16 bytes. Each byte takes 2 cycles, and cpu_stall stays high for exactly 2 cycles per byte.
- R5: Byte i is read at source+i and then written, with the same value, to destination+i on the following cycle.
- R6: A control write starts copying at once when blanking mode was off and stays off, or when vid_mode is 0. Otherwise nothing is copied at that write.
- R7: At the end of a batch cpu_stall falls, and the address registers then read back source+count and destination+count.
- R8: A control write stores {0, bits [6:0]} into the control register. When a bulk transfer completes, the control register reads 0xFF.
- R9: In blanking mode each start copies 16 bytes and then decrements the control register. The mode ends when the control register reaches 0xFF, so n+1 blocks are copied in total.
- R10: While blanking mode is active and the engine is idle, each change of vid_mode from a nonzero value to 0 starts the next block. Remaining in mode 0 starts nothing more.
- R11: Writing a control byte with bit 7 clear while blanking mode is active and vid_mode is nonzero ends the mode without copying anything.
- R12: Register writes made while cpu_stall is high are ignored.
- R13: After reset every register reads 0, cpu_stall is low and blanking mode is off. Register selects 0–4 are: source high, source low, destination high, destination low, control. Other selects read 0xFF and ignore writes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_wr | input | 1 | Register write strobe |
| cfg_sel | input | 3 | Register select |
| cfg_wdata | input | 8 | Register write data |
| cfg_rdata | output | 8 | Read-back of the selected register |
| vid_mode | input | 2 | Current video mode; 0 is horizontal blank |
| bus_addr | output | 16 | Bus master address |
| bus_rd | output | 1 | Bus read cycle; data is expected on bus_rdata in the same cycle |
| bus_wr | output | 1 | Bus write cycle |
| bus_wdata | output | 8 | Bus write data |
| bus_rdata | input | 8 | Bus read data |
| cpu_stall | output | 1 | Holds the processor while a batch runs |

## Verification
The bench uses the default block size of 16 bytes, so each blanking start copies 16 bytes and the largest bulk length is 2048 bytes. At that size a full-length transfer of 4096 stalled cycles can be run, and so can a destination at the top of video RAM (0x9FF0) that runs past 0x9FFF. The small random lengths keep many transfers, and many rejected sources, within the cycle budget.

// File: rtl/vram_block_dma.sv
module vram_block_dma #(
  parameter int BLK_BYTES = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cfg_wr,
  input  logic [2:0]  cfg_sel,
  input  logic [7:0]  cfg_wdata,
  output logic [7:0]  cfg_rdata,
  input  logic [1:0]  vid_mode,
  output logic [15:0] bus_addr,
  output logic        bus_rd,
  output logic        bus_wr,
  output logic [7:0]  bus_wdata,
  input  logic [7:0]  bus_rdata,
  output logic        cpu_stall
);
  localparam int SH = $clog2(BLK_BYTES);
  localparam int CW = 8 + SH;
  localparam logic [15:0] ALIGN = 16'(BLK_BYTES - 1);

  logic [7:0]  src_hi, src_lo, dst_hi, dst_lo, ctl, lat;
  logic [15:0] src, dst;
  logic [CW-1:0] left;
  logic        busy, phase, hb;
  logic [1:0]  mode_q;

  wire [15:0] src_cap  = {src_hi, src_lo} & ~ALIGN;
  wire        src_bad  = src_cap[15:13] == 3'b100;
  wire [15:0] dst_cap  = ({dst_hi, dst_lo} & (16'h1FFF & ~ALIGN)) | 16'h8000;
  wire        ctl_wr   = cfg_wr && !busy && cfg_sel == 3'd4;
  wire        go_now   = (!hb && !cfg_wdata[7]) || vid_mode == 2'd0;
  wire        hb_entry = hb && !busy && vid_mode == 2'd0 && mode_q != 2'd0;
  wire [7:0]  blocks   = {1'b0, cfg_wdata[6:0]} + 8'd1;
  wire [15:0] src_n    = src + 16'd1;
  wire [15:0] dst_n    = dst + 16'd1;
  wire [7:0]  ctl_dec  = ctl - 8'd1;

  assign bus_rd    = busy && !phase;
  assign bus_wr    = busy && phase;
  assign bus_addr  = phase ? dst : src;
  assign bus_wdata = lat;
  assign cpu_stall = busy;

  always_comb begin
    case (cfg_sel)
      3'd0:    cfg_rdata = src_hi;
      3'd1:    cfg_rdata = src_lo;
      3'd2:    cfg_rdata = dst_hi;
      3'd3:    cfg_rdata = dst_lo;
      3'd4:    cfg_rdata = ctl;
      default: cfg_rdata = 8'hFF;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      src_hi <= '0; src_lo <= '0; dst_hi <= '0; dst_lo <= '0; ctl <= '0;
      src <= '0; dst <= '0; left <= '0; lat <= '0;
      busy <= 1'b0; phase <= 1'b0; hb <= 1'b0; mode_q <= '0;
    end else begin
      mode_q <= vid_mode;
      if (cfg_wr && !busy) begin
        case (cfg_sel)
          3'd0: src_hi <= cfg_wdata;
          3'd1: src_lo <= cfg_wdata;
          3'd2: dst_hi <= cfg_wdata;
          3'd3: dst_lo <= cfg_wdata;
          default: ;
        endcase
      end
      if (ctl_wr) begin
        if (!src_bad) begin
          src <= src_cap;
          dst <= dst_cap;
          hb  <= cfg_wdata[7];
          ctl <= {1'b0, cfg_wdata[6:0]};
          if (go_now) begin
            busy  <= 1'b1;
            phase <= 1'b0;
            left  <= cfg_wdata[7] ? CW'(BLK_BYTES) : (CW'(blocks) << SH);
          end
        end
      end else if (hb_entry) begin
        busy  <= 1'b1;
        phase <= 1'b0;
        left  <= CW'(BLK_BYTES);
      end else if (busy) begin
        if (!phase) begin
          lat   <= bus_rdata;
          phase <= 1'b1;
        end else begin
          phase <= 1'b0;
          src   <= src_n;
          dst   <= dst_n;
          left  <= left - CW'(1);
          if (left == CW'(1)) begin
            busy   <= 1'b0;
            src_hi <= src_n[15:8];
            src_lo <= src_n[7:0];
            dst_hi <= dst_n[15:8];
            dst_lo <= dst_n[7:0];
            if (hb) begin
              ctl <= ctl_dec;
              if (ctl_dec == 8'hFF) hb <= 1'b0;
            end else begin
              ctl <= 8'hFF;
            end
          end
        end
      end
    end
  end

  p_src_aligned_r1: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |-> (bus_rd && (bus_addr & ALIGN) == 16'd0));

  p_reject_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_wr && src_bad) |=> !cpu_stall);

  p_dst_vram_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(cpu_stall) |=> (bus_wr && bus_addr[15:13] == 3'b100 && (bus_addr & ALIGN) == 16'd0));

  p_copy_r5: assert property (@(posedge clk) disable iff (!rst_n)
    bus_rd |=> (bus_wr && bus_wdata == $past(bus_rdata)));

  p_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_stall) |-> $past(bus_wr));
endmodule

// File: tb/sim_vram_block_dma.sv
module sim_vram_block_dma;
  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_wr = 1'b0;
  logic [2:0] cfg_sel = '0;
  logic [7:0] cfg_wdata = '0, cfg_rdata;
  logic [1:0] vid_mode = 2'd1;
  logic [15:0] bus_addr;
  logic bus_rd, bus_wr, cpu_stall;
  logic [7:0] bus_wdata, bus_rdata;

  int total = 0, bad = 0, wcount = 0, scount = 0;
  logic [7:0] wmem [logic [15:0]];

  function automatic logic [7:0] pat(input logic [15:0] a);
    return a[7:0] ^ {a[11:8], a[15:12]} ^ 8'hA5;
  endfunction

  assign bus_rdata = pat(bus_addr);

  always #2 clk = ~clk;

  vram_block_dma u0 (
    .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata), .vid_mode(vid_mode),
    .bus_addr(bus_addr), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .cpu_stall(cpu_stall)
  );

  always @(posedge clk) begin
    if (bus_wr) begin wmem[bus_addr] = bus_wdata; wcount++; end
    if (cpu_stall) scount++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] s, input logic [7:0] d);
    @(negedge clk); cfg_wr = 1'b1; cfg_sel = s; cfg_wdata = d;
    @(negedge clk); cfg_wr = 1'b0;
  endtask

  task automatic rd(input logic [2:0] s, output logic [7:0] d);
    @(negedge clk); cfg_sel = s; #1 d = cfg_rdata;
  endtask

  task automatic wait_idle();
    int k = 0;
    while (cpu_stall && k < 10000) begin @(negedge clk); k++; end
    repeat (2) @(negedge clk);
  endtask

  task automatic clear_log();
    wmem.delete(); wcount = 0; scount = 0;
  endtask

  function automatic int mism(input logic [15:0] s, input logic [15:0] d, input int n);
    int e = 0;
    for (int i = 0; i < n; i++) begin
      if (!wmem.exists(16'(d + i)) || wmem[16'(d + i)] != pat(16'(s + i))) e++;
    end
    return e;
  endfunction

  task automatic check_addr(input logic [15:0] s, input logic [15:0] d, input string req);
    logic [7:0] a, b;
    rd(0, a); rd(1, b); chk({a, b} == s, req, {a, b}, s);
    rd(2, a); rd(3, b); chk({a, b} == d, req, {a, b}, d);
  endtask

  task automatic run_gen(input logic [15:0] sa, input logic [15:0] da, input logic [7:0] c,
                         input logic [1:0] vm);
    logic [15:0] s, d;
    logic [7:0] prev, v;
    int n;
    @(negedge clk); vid_mode = vm;
    wr(0, sa[15:8]); wr(1, sa[7:0]); wr(2, da[15:8]); wr(3, da[7:0]);
    rd(4, prev);
    clear_log();
    wr(4, c);
    wait_idle();
    s = sa & 16'hFFF0;
    d = (da & 16'h1FF0) | 16'h8000;
    if (s[15:13] == 3'b100) begin
      chk(wcount == 0 && scount == 0, "R2 reject no copy", wcount, 0);
      rd(4, v); chk(v == prev, "R2 ctl kept", v, prev);
      check_addr(sa, da, "R2 addr kept");
    end else begin
      n = (int'(c[6:0]) + 1) * 16;
      chk(wcount == n, "R4 byte count", wcount, n);
      chk(scount == 2 * n, "R4 stall cycles", scount, 2 * n);
      chk(mism(s, d, n) == 0, "R1 R3 R5 content", mism(s, d, n), 0);
      check_addr(16'(s + n), 16'(d + n), "R7 writeback");
      rd(4, v); chk(v == 8'hFF, "R8 bulk done", v, 8'hFF);
    end
  endtask

  task automatic pulse_blank(input logic [1:0] other);
    @(negedge clk); vid_mode = other;
    repeat (3) @(negedge clk);
    vid_mode = 2'd0;
    @(negedge clk);
    wait_idle();
  endtask

  initial begin
    #(4 * 150000);
    $display("FAIL watchdog act=0 exp=1");
    bad++;
    $display("  test done: total=%0d bad=%0d", total + 1, bad);
    $finish;
  end

  initial begin
    logic [7:0] v;
    logic [15:0] s, d;
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < 5; i++) begin
      rd(3'(i), v); chk(v == 8'h00, "R13 reset reg", v, 0);
    end
    rd(3'd6, v); chk(v == 8'hFF, "R13 unused select", v, 8'hFF);
    chk(cpu_stall == 1'b0, "R13 stall low", cpu_stall, 0);

    run_gen(16'h1237, 16'hFFFF, 8'h00, 2'd1);
    run_gen(16'hC00F, 16'h0123, 8'h7F, 2'd3);
    run_gen(16'h8000, 16'h0000, 8'h02, 2'd1);
    run_gen(16'h9FFF, 16'h0040, 8'h00, 2'd2);
    run_gen(16'h7FF0, 16'h1FF0, 8'h01, 2'd0);
    run_gen(16'hA000, 16'h0000, 8'h00, 2'd1);

    for (int i = 0; i < 24; i++) begin
      logic [15:0] ra, rb;
      ra = 16'($urandom);
      if ($urandom_range(0, 3) == 0) ra[15:13] = 3'b100;
      rb = 16'($urandom);
      run_gen(ra, rb, 8'($urandom_range(0, 5)), 2'($urandom_range(1, 3)));
    end

    // blanking mode started immediately in mode 0, three blocks
    @(negedge clk); vid_mode = 2'd0;
    wr(0, 8'h45); wr(1, 8'h6B); wr(2, 8'h03); wr(3, 8'h20);
    s = 16'h4560; d = 16'h8320;
    clear_log();
    wr(4, 8'h82);
    wait_idle();
    chk(wcount == 16, "R6 R9 first block", wcount, 16);
    rd(4, v); chk(v == 8'h01, "R9 ctl dec", v, 8'h01);
    check_addr(16'(s + 16), 16'(d + 16), "R7 block writeback");
    repeat (20) @(negedge clk);
    chk(wcount == 16, "R10 no restart in mode 0", wcount, 16);
    pulse_blank(2'd2);
    chk(wcount == 32, "R10 second block", wcount, 32);
    rd(4, v); chk(v == 8'h00, "R9 ctl dec 2", v, 8'h00);
    pulse_blank(2'd3);
    chk(wcount == 48, "R10 third block", wcount, 48);
    rd(4, v); chk(v == 8'hFF, "R9 wrap ends", v, 8'hFF);
    pulse_blank(2'd1);
    chk(wcount == 48, "R9 mode off", wcount, 48);
    chk(mism(s, d, 48) == 0, "R5 blank content", mism(s, d, 48), 0);

    // blanking mode written outside mode 0: deferred
    @(negedge clk); vid_mode = 2'd2;
    wr(0, 8'h20); wr(1, 8'h00); wr(2, 8'h1F); wr(3, 8'hF0);
    clear_log();
    wr(4, 8'h80);
    repeat (10) @(negedge clk);
    chk(wcount == 0 && scount == 0, "R6 deferred", wcount, 0);
    rd(4, v); chk(v == 8'h00, "R8 ctl stored", v, 8'h00);
    pulse_blank(2'd2);
    chk(wcount == 16, "R10 deferred block", wcount, 16);
    chk(mism(16'h2000, 16'h9FF0, 16) == 0, "R3 top of vram", mism(16'h2000, 16'h9FF0, 16), 0);
    rd(4, v); chk(v == 8'hFF, "R9 single block ends", v, 8'hFF);

    // cancel
    @(negedge clk); vid_mode = 2'd3;
    clear_log();
    wr(4, 8'h81);
    wr(4, 8'h05);
    repeat (4) @(negedge clk);
    chk(wcount == 0, "R11 cancel no copy", wcount, 0);
    pulse_blank(2'd3);
    chk(wcount == 0 && scount == 0, "R11 mode ended", wcount, 0);

    // writes while stalled
    @(negedge clk); vid_mode = 2'd1;
    wr(0, 8'h30); wr(1, 8'h00); wr(2, 8'h00); wr(3, 8'h00);
    clear_log();
    wr(4, 8'h03);
    wr(0, 8'h77);
    wr(4, 8'h80);
    wr(3, 8'h55);
    wait_idle();
    chk(wcount == 64, "R12 length kept", wcount, 64);
    check_addr(16'h3040, 16'h8040, "R12 regs kept");
    rd(4, v); chk(v == 8'hFF, "R12 ctl kept", v, 8'hFF);
    repeat (5) @(negedge clk);
    pulse_blank(2'd2);
    chk(wcount == 64, "R12 mode not set", wcount, 64);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule